// File: doc/BRIEF.md
# Banked Cartridge Controller with Scanline Interrupt

This block sits between a console CPU, its picture processor (PPU) and the cartridge ROMs. The CPU reaches its bank registers indirectly. A write to the command location picks one of eight bank slots and sets two layout flags. The next write to the data location fills the chosen slot. Program ROM is seen through four 8 KiB windows. Character memory is cut into two 2 KiB windows and four 1 KiB windows. An optional 8 KiB work RAM in the $6000-$7FFF range can be enabled.

The block also counts rendered lines. Each line where background and sprites fetch from opposite pattern-table halves produces one rise of PPU address bit 12. The block takes a rise as a count only if bit 12 was low for long enough before it. The count is relative: a value written to the latch means "this many lines from now". When the countdown reaches zero with interrupts enabled, the interrupt line is raised. It stays high until software acknowledges it.

CPU writes are decoded from address bits 15..13 and bit 0. In the 8000 page, even addresses are the command and odd addresses are the data. In the A000 page, odd addresses hold the RAM enable. In the C000 page, even addresses hold the latch and odd addresses hold the reload request. In the E000 page, even addresses disable the interrupt and odd addresses enable it.

Top module: `scanline_bank_mapper`

## Requirements
- R1: A CPU write with cpu_we high to an even address in $8000-$9FFF stores the slot index from data bits 2:0, the PRG layout flag from bit 6 and the CHR layout flag from bit 7. A write to an odd address in that page loads the indexed slot. PRG slots keep only their low PRG_BANK_BITS bits.
- R2: With the PRG flag at 0, $8000 maps to slot 6, $A000 to slot 7 and $C000 to the second-last bank. With the defaults (64 banks) the second-last bank is 62.
- R3: With the PRG flag at 1, $C000 maps to slot 6 and $8000 to the second-last bank. $A000 stays on slot 7.
- R4: $E000-$FFFF always maps to the last bank (63 with the defaults). In every window, CPU address bits 12:0 pass straight through to prg_rom_addr.
- R5: With the CHR flag at 0, PPU $0000-$07FF uses slot 0 and $0800-$0FFF uses slot 1. In both, the slot's bit 0 is replaced by PPU address bit 10. PPU $1000, $1400, $1800 and $1C00 use slots 2 to 5 as whole 1 KiB banks.
- R6: With the CHR flag at 1, the two pattern-table halves trade places. The 2 KiB pair serves $1000-$1FFF and the 1 KiB slots serve $0000-$0FFF.
- R7: A rise of ppu_addr[12] counts only if that bit was low on at least A12_LOW_MIN (default 3) consecutive clock edges just before the rise. Shorter low spells are ignored.
- R8: On each counted rise, the counter is handled in one of two ways. It is reloaded from the latch if it is zero or a reload is pending. Otherwise it is decremented. If the new value is zero and interrupts are enabled, irq goes high on that edge and stays high.
- R9: A write to an even address in $C000-$DFFF sets the latch. A write to an odd address there makes the next counted rise reload the counter, even if the counter is not zero.
- R10: A write to an even address in $E000-$FFFF disables interrupts and drops irq on the next edge. Counting continues, but no interrupt is raised. A write to an odd address there enables interrupts.
- R11: wram_en is high only when data bit 7 of the last write to an odd address in $A000-$BFFF was 1 and cpu_addr lies in $6000-$7FFF.
- R12: After reset, irq and wram_en are low, both layout flags are 0 and every slot holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU bus clock; also samples the PPU address |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | Write strobe, high for one clock per write |
| ppu_addr | input | 14 | PPU address bus |
| prg_rom_addr | output | PRG_BANK_BITS+13 | Banked program ROM address |
| chr_rom_addr | output | CHR_BANK_BITS+10 | Banked character memory address |
| wram_en | output | 1 | Work RAM select |
| irq | output | 1 | Interrupt request, active high |

## Verification
The window mapping is tried with each layout flag at both values. Each slot is probed through the window where it lands, so a swapped window or a wrong fixed bank shows up as a wrong bank number. The 2 KiB slots are probed in both of their halves, to show that the low slot bit is replaced by the PPU address bit. The line counter is driven with rises after low spells that are long, exactly the threshold, and one or two clocks short. The checks tell apart a counted rise and a filtered glitch, a plain decrement and a forced reload, and an enabled, acknowledged and disabled interrupt.

// File: rtl/scanline_bank_mapper.sv
module scanline_bank_mapper #(
  parameter int PRG_BANK_BITS = 6,
  parameter int CHR_BANK_BITS = 8,
  parameter int A12_LOW_MIN   = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [15:0]                cpu_addr,
  input  logic [7:0]                 cpu_wdata,
  input  logic                       cpu_we,
  input  logic [13:0]                ppu_addr,
  output logic [PRG_BANK_BITS+12:0]  prg_rom_addr,
  output logic [CHR_BANK_BITS+9:0]   chr_rom_addr,
  output logic                       wram_en,
  output logic                       irq
);

  localparam int LW = $clog2(A12_LOW_MIN + 1);
  localparam logic [LW-1:0] LOW_SAT = LW'(A12_LOW_MIN);
  localparam logic [PRG_BANK_BITS-1:0] PRG_LAST = '1;
  localparam logic [PRG_BANK_BITS-1:0] PRG_PENULT =
    PRG_LAST - {{(PRG_BANK_BITS-1){1'b0}}, 1'b1};

  logic [7:0] slot_q [8];
  logic [2:0] sel_q;
  logic       prg_swap_q, chr_swap_q, ram_on_q;
  logic [7:0] latch_q, cnt_q, cnt_nx;
  logic       reload_q, irq_en_q, irq_q;
  logic [LW-1:0] low_cnt_q;

  wire       wr_hi   = cpu_we && cpu_addr[15];
  wire [1:0] wpage   = cpu_addr[14:13];
  wire       wodd    = cpu_addr[0];
  wire       wr_cmd  = wr_hi && wpage == 2'd0 && !wodd;
  wire       wr_data = wr_hi && wpage == 2'd0 &&  wodd;
  wire       wr_ram  = wr_hi && wpage == 2'd1 &&  wodd;
  wire       wr_lat  = wr_hi && wpage == 2'd2 && !wodd;
  wire       wr_rld  = wr_hi && wpage == 2'd2 &&  wodd;
  wire       wr_off  = wr_hi && wpage == 2'd3 && !wodd;
  wire       wr_on   = wr_hi && wpage == 2'd3 &&  wodd;

  wire a12      = ppu_addr[12];
  wire a12_tick = a12 && (low_cnt_q >= LOW_SAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) slot_q[i] <= '0;
      sel_q      <= '0;
      prg_swap_q <= 1'b0;
      chr_swap_q <= 1'b0;
      ram_on_q   <= 1'b0;
    end else begin
      if (wr_cmd) begin
        sel_q      <= cpu_wdata[2:0];
        prg_swap_q <= cpu_wdata[6];
        chr_swap_q <= cpu_wdata[7];
      end
      if (wr_data) slot_q[sel_q] <= cpu_wdata;
      if (wr_ram)  ram_on_q <= cpu_wdata[7];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                low_cnt_q <= '0;
    else if (a12)              low_cnt_q <= '0;
    else if (low_cnt_q != LOW_SAT) low_cnt_q <= low_cnt_q + 1'b1;
  end

  always_comb begin
    if (cnt_q == 8'd0 || reload_q) cnt_nx = latch_q;
    else                           cnt_nx = cnt_q - 8'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q  <= '0;
      cnt_q    <= '0;
      reload_q <= 1'b0;
      irq_en_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (a12_tick) begin
        cnt_q    <= cnt_nx;
        reload_q <= 1'b0;
        if (cnt_nx == 8'd0 && irq_en_q) irq_q <= 1'b1;
      end
      if (wr_lat) latch_q  <= cpu_wdata;
      if (wr_rld) reload_q <= 1'b1;
      if (wr_on)  irq_en_q <= 1'b1;
      if (wr_off) begin
        irq_en_q <= 1'b0;
        irq_q    <= 1'b0;
      end
    end
  end

  logic [PRG_BANK_BITS-1:0] prg_bank;
  always_comb begin
    unique case (cpu_addr[14:13])
      2'd0: prg_bank = prg_swap_q ? PRG_PENULT : slot_q[6][PRG_BANK_BITS-1:0];
      2'd1: prg_bank = slot_q[7][PRG_BANK_BITS-1:0];
      2'd2: prg_bank = prg_swap_q ? slot_q[6][PRG_BANK_BITS-1:0] : PRG_PENULT;
      default: prg_bank = PRG_LAST;
    endcase
  end

  wire [2:0] chr_win = ppu_addr[12:10] ^ {chr_swap_q, 2'b00};
  logic [7:0] chr_slot;
  logic [CHR_BANK_BITS-1:0] chr_bank;
  always_comb begin
    if (!chr_win[2]) begin
      chr_slot = slot_q[{2'b00, chr_win[1]}];
      chr_bank = {chr_slot[CHR_BANK_BITS-1:1], chr_win[0]};
    end else begin
      chr_slot = slot_q[3'd2 + {1'b0, chr_win[1:0]}];
      chr_bank = chr_slot[CHR_BANK_BITS-1:0];
    end
  end

  assign prg_rom_addr = {prg_bank, cpu_addr[12:0]};
  assign chr_rom_addr = {chr_bank, ppu_addr[9:0]};
  assign wram_en      = ram_on_q && cpu_addr[15:13] == 3'b011;
  assign irq          = irq_q;

  a_r1_data_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && sel_q == 3'd6) |=> slot_q[6] == $past(cpu_wdata));

  a_r4_last_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:13] == 3'b111) |-> prg_rom_addr[PRG_BANK_BITS+12:13] == PRG_LAST);

  a_r8_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !a12_tick |=> $stable(cnt_q));

  a_r8_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(a12_tick) && $past(irq_en_q)));

  a_r10_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    wr_off |=> !irq);

endmodule

// File: tb/scanline_bank_mapper_tb.sv
module scanline_bank_mapper_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_we = 1'b0;
  logic [13:0] ppu_addr = '0;
  logic [18:0] prg_rom_addr;
  logic [17:0] chr_rom_addr;
  logic        wram_en, irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scanline_bank_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .ppu_addr(ppu_addr), .prg_rom_addr(prg_rom_addr),
    .chr_rom_addr(chr_rom_addr), .wram_en(wram_en), .irq(irq));

  // {req, kind(0 prg / 1 chr), cmd, data, probe, expected bank}
  localparam logic [47:0] VEC [NV] = '{
    {4'd2, 4'd0, 8'h06, 8'h05, 16'h8000, 8'd5},
    {4'd2, 4'd0, 8'h06, 8'h05, 16'hC000, 8'd62},
    {4'd3, 4'd0, 8'h46, 8'h09, 16'hC000, 8'd9},
    {4'd3, 4'd0, 8'h46, 8'h09, 16'h8000, 8'd62},
    {4'd1, 4'd0, 8'h07, 8'h0C, 16'hA000, 8'd12},
    {4'd4, 4'd0, 8'h47, 8'h0D, 16'hE000, 8'd63},
    {4'd1, 4'd0, 8'h06, 8'h45, 16'h8000, 8'd5},
    {4'd5, 4'd1, 8'h00, 8'h11, 16'h0000, 8'h10},
    {4'd5, 4'd1, 8'h00, 8'h11, 16'h0400, 8'h11},
    {4'd5, 4'd1, 8'h01, 8'h20, 16'h0C00, 8'h21},
    {4'd5, 4'd1, 8'h02, 8'h33, 16'h1000, 8'h33},
    {4'd5, 4'd1, 8'h05, 8'h44, 16'h1C00, 8'h44},
    {4'd6, 4'd1, 8'h82, 8'h55, 16'h0000, 8'h55},
    {4'd6, 4'd1, 8'h80, 8'h60, 16'h1400, 8'h61},
    {4'd6, 4'd1, 8'h85, 8'h77, 16'h0C00, 8'h77}
  };

  function automatic string rq(input logic [3:0] k);
    case (k)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic a12_pulse(input int low_clks);
    @(negedge clk);
    ppu_addr[12] = 1'b0;
    repeat (low_clks) @(negedge clk);
    ppu_addr[12] = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got 0 expected 1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    cpu_addr = 16'h6000; #1;
    check(wram_en == 1'b0, "R12", wram_en, 0);
    check(irq == 1'b0, "R12", irq, 0);
    cpu_addr = 16'h8000; #1;
    check(prg_rom_addr[18:13] == 6'd0, "R12", prg_rom_addr[18:13], 0);
    cpu_addr = 16'hC000; #1;
    check(prg_rom_addr[18:13] == 6'd62, "R12", prg_rom_addr[18:13], 62);

    for (int i = 0; i < NV; i++) begin
      cpu_write(16'h8000, VEC[i][39:32]);
      cpu_write(16'h8001, VEC[i][31:24]);
      if (VEC[i][40] == 1'b0) begin
        cpu_addr = VEC[i][23:8]; #1;
        check(prg_rom_addr[18:13] == VEC[i][5:0], rq(VEC[i][47:44]),
              prg_rom_addr[18:13], VEC[i][7:0]);
      end else begin
        ppu_addr = VEC[i][21:8]; #1;
        check(chr_rom_addr[17:10] == VEC[i][7:0], rq(VEC[i][47:44]),
              chr_rom_addr[17:10], VEC[i][7:0]);
      end
    end

    // R4 offset pass-through
    cpu_addr = 16'hF5A3; #1;
    check(prg_rom_addr == {6'd63, 13'h15A3}, "R4", prg_rom_addr, {6'd63, 13'h15A3});

    // R11 work RAM enable
    cpu_write(16'hA001, 8'h80);
    cpu_addr = 16'h6000; #1;
    check(wram_en == 1'b1, "R11", wram_en, 1);
    cpu_addr = 16'h8000; #1;
    check(wram_en == 1'b0, "R11", wram_en, 0);
    cpu_write(16'hA001, 8'h00);
    cpu_addr = 16'h7FFF; #1;
    check(wram_en == 1'b0, "R11", wram_en, 0);

    // R8 countdown with latch 2
    ppu_addr = 14'h1000;
    cpu_write(16'hC000, 8'd2);
    cpu_write(16'hC001, 8'd0);
    cpu_write(16'hE001, 8'd0);
    a12_pulse(4); check(irq == 1'b0, "R8", irq, 0);
    a12_pulse(4); check(irq == 1'b0, "R8", irq, 0);
    a12_pulse(1); a12_pulse(2);
    check(irq == 1'b0, "R7", irq, 0);
    a12_pulse(4); check(irq == 1'b1, "R8", irq, 1);

    // R10 ack and disable
    cpu_write(16'hE000, 8'd0);
    #1 check(irq == 1'b0, "R10", irq, 0);
    a12_pulse(4); a12_pulse(4); a12_pulse(4);
    check(irq == 1'b0, "R10", irq, 0);

    // R9 reload request mid-count
    cpu_write(16'hE001, 8'd0);
    cpu_write(16'hC000, 8'd5);
    cpu_write(16'hC001, 8'd0);
    a12_pulse(4); a12_pulse(4);
    cpu_write(16'hC000, 8'd1);
    cpu_write(16'hC001, 8'd0);
    a12_pulse(4); check(irq == 1'b0, "R9", irq, 0);
    a12_pulse(4); check(irq == 1'b1, "R9", irq, 1);
    cpu_write(16'hE000, 8'd0);

    // R7 threshold boundary
    cpu_write(16'hE001, 8'd0);
    cpu_write(16'hC000, 8'd1);
    cpu_write(16'hC001, 8'd0);
    a12_pulse(3); check(irq == 1'b0, "R7", irq, 0);
    a12_pulse(2); check(irq == 1'b0, "R7", irq, 0);
    a12_pulse(3); check(irq == 1'b1, "R7", irq, 1);

    finish_run();
  end
endmodule